// File: doc/BRIEF.md
# UART Transmit Descriptor Ring Engine

This block sends a chain of byte buffers out of a UART transmit pin. A host fills a small internal data memory with bytes and describes each buffer in a descriptor with three words: a status word, a length and a start index into the data memory. The host then hands a descriptor to the engine by setting its Ready flag. The engine visits descriptors in ring order, starting at a programmable base index. For each ready buffer it serializes the bytes in order, then returns the descriptor to the host by clearing Ready. It then moves on to the next descriptor, or back to the base when the descriptor is marked as the last one.

Control bits in each descriptor set the behaviour per buffer. One raises an event flag when the buffer completes. Another chooses between starting the next buffer at once or waiting for a three-bit idle gap; the same bit also enables reporting of a lost clear-to-send as an early end of the buffer. A third marks every character of the buffer as a multidrop address character, carried in a ninth frame bit. The CTS input gates the start of every character.

Top module: `uart_txring`

## Requirements
- R1: After reset, txd is 1 and tx_event is 0. The engine waits at descriptor ring_base and sends nothing until that descriptor becomes ready.
- R2: A descriptor whose status bit 15 (Ready) is 0 is not transmitted. The engine keeps waiting on it and txd stays 1.
- R3: Each character is a frame of one 0 start bit, then the 8 data bits LSB first, then a 1 stop bit, each bit lasting bit_div clocks. A buffer sends length bytes (descriptor word 1) from consecutive data-memory addresses, starting at the start index (descriptor word 2).
- R4: When a buffer completes, the engine clears Ready in its status word (word 0) and sets bit 0 to the CT outcome. Bits 14 to 1 stay as the host wrote them, and the reserved bits 14 and 9 to 1 have no effect on transmission.
- R5: After a descriptor with bit 13 (Wrap) set, the next descriptor is ring_base. Otherwise it is the next index, modulo the ring size.
- R6: A serviced descriptor with bit 12 (Interrupt) set sets tx_event. With bit 12 clear, tx_event does not change. A one-cycle pulse on evt_clear clears tx_event.
- R7: With bit 11 (CR) clear, the next ready buffer's start bit follows the previous stop bit within one bit time. With CR set, the idle gap is at least three and less than four bit times.
- R8: With multidrop at 1, a ninth bit between the data bits and the stop bit carries the buffer's bit 10 (Address). With multidrop at 0, no ninth bit is sent.
- R9: No character starts while cts is 0. With CR clear, a buffer that is paused this way resumes when cts returns, sends all its bytes, and ends with bit 0 (CT) at 0.
- R10: With CR set, if cts is 0 when the next character of a started buffer is due, the character in flight still finishes. The buffer then ends with CT (bit 0) set and Ready cleared, tx_event follows bit 12, and the engine moves to the next descriptor.
- R11: Host writes to any word of a descriptor whose Ready bit is 1 are ignored.
- R12: A ready buffer of length 0 sends no character and is returned with Ready cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 selects descriptor space, 1 selects data memory |
| host_addr | input | HA_W | Descriptor space: {index, word[1:0]}. Data space: byte address |
| host_wdata | input | 16 | Host write data (data memory uses bits 7:0) |
| host_rdata | output | 16 | Combinational read of the addressed location |
| evt_clear | input | 1 | Write-one pulse that clears tx_event |
| ring_base | input | log2(DESC_NUM) | First descriptor index of the ring |
| bit_div | input | DIV_W | Clocks per serial bit (at least 1) |
| multidrop | input | 1 | Enables the ninth address/data bit |
| cts | input | 1 | Clear to send, 1 allows characters to start |
| txd | output | 1 | Serial transmit line, idle high |
| tx_event | output | 1 | Sticky buffer-serviced event flag |

## Verification
The hardest case to reach from the ports is a clear-to-send drop that falls exactly inside a buffer, after its first character has started but before the next one is due. The bench watches txd for the falling start edge of the first character and lowers cts on that cycle. It then decodes the frame in flight and checks that the line stays idle. Finally it reads back the status word to see whether the buffer was aborted with CT set or only paused. The idle-gap checks use the same start-edge watching and count the idle clocks between the middle of one stop bit and the next start edge.

// File: rtl/uart_txring_pkg.sv
package uart_txring_pkg;
   localparam int unsigned RDY_B  = 15;
   localparam int unsigned WRAP_B = 13;
   localparam int unsigned IRQ_B  = 12;
   localparam int unsigned CR_B   = 11;
   localparam int unsigned ADR_B  = 10;
   localparam int unsigned CT_B   = 0;

   typedef enum logic [2:0] {
      ST_POLL,
      ST_CHAR,
      ST_WAIT,
      ST_WB,
      ST_GAP
   } eng_st_t;
endpackage

// File: rtl/uart_txring_desc.sv
module uart_txring_desc
   import uart_txring_pkg::*;
#(
   parameter int DESC_NUM = 8,
   localparam int IDX_W = $clog2(DESC_NUM)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             host_we,
   input  logic [IDX_W-1:0] host_idx,
   input  logic [1:0]       host_word,
   input  logic [15:0]      host_wdata,
   output logic [15:0]      host_rdata,
   input  logic [IDX_W-1:0] eng_idx,
   output logic [15:0]      eng_status,
   output logic [15:0]      eng_len,
   output logic [15:0]      eng_ptr,
   input  logic             eng_wb,
   input  logic             eng_wb_ct
);
   logic [15:0] st_q  [DESC_NUM];
   logic [15:0] len_q [DESC_NUM];
   logic [15:0] ptr_q [DESC_NUM];
   logic        host_locked;

   assign host_locked = st_q[host_idx][RDY_B];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DESC_NUM; i++) begin
            st_q[i]  <= '0;
            len_q[i] <= '0;
            ptr_q[i] <= '0;
         end
      end else begin
         if (host_we && !host_locked) begin
            case (host_word)
               2'd0:    st_q[host_idx]  <= host_wdata;
               2'd1:    len_q[host_idx] <= host_wdata;
               2'd2:    ptr_q[host_idx] <= host_wdata;
               default: ;
            endcase
         end
         if (eng_wb)
            st_q[eng_idx] <= {1'b0, st_q[eng_idx][14:1], eng_wb_ct};
      end
   end

   always_comb begin
      case (host_word)
         2'd0:    host_rdata = st_q[host_idx];
         2'd1:    host_rdata = len_q[host_idx];
         2'd2:    host_rdata = ptr_q[host_idx];
         default: host_rdata = '0;
      endcase
   end

   assign eng_status = st_q[eng_idx];
   assign eng_len    = len_q[eng_idx];
   assign eng_ptr    = ptr_q[eng_idx];

   // R11: a length write to an owned descriptor leaves it as it was
   assert_locked_len_R11: assert property (@(posedge clk) disable iff (rst)
      (host_we && host_word == 2'd1 && host_locked)
      |=> len_q[$past(host_idx)] == $past(len_q[host_idx]));

   // R4: write-back always returns ownership to the host
   assert_wb_release_R4: assert property (@(posedge clk) disable iff (rst)
      eng_wb |=> !st_q[$past(eng_idx)][RDY_B]);
endmodule

// File: rtl/uart_txring_dram.sv
module uart_txring_dram #(
   parameter int DEPTH = 64,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   input  logic [AW-1:0] eng_addr,
   output logic [7:0]    eng_rdata
);
   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (host_we) mem_q[host_addr] <= host_wdata;
   end

   assign host_rdata = mem_q[host_addr];
   assign eng_rdata  = mem_q[eng_addr];
endmodule

// File: rtl/uart_txring_ser.sv
module uart_txring_ser #(
   parameter int DIV_W    = 12,
   parameter bit NINTH_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [7:0]       data,
   input  logic             ninth_on,
   input  logic             ninth_val,
   input  logic [DIV_W-1:0] div,
   output logic             txd,
   output logic             busy,
   output logic             done
);
   localparam int FW = 11;

   logic [FW-1:0]    frame;
   logic [3:0]       nbits;
   logic [FW-1:0]    sh_q;
   logic [3:0]       nb_q;
   logic [DIV_W-1:0] cc_q;
   logic             busy_q;
   logic             done_q;

   generate
      if (NINTH_EN) begin : g_nine
         assign frame = ninth_on ? {1'b1, ninth_val, data, 1'b0} : {2'b11, data, 1'b0};
         assign nbits = ninth_on ? 4'd11 : 4'd10;
      end else begin : g_plain
         logic unused_nine;
         assign unused_nine = ninth_on ^ ninth_val;
         assign frame = {2'b11, data, 1'b0};
         assign nbits = 4'd10;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '1;
         nb_q   <= '0;
         cc_q   <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            sh_q   <= frame;
            nb_q   <= nbits;
            cc_q   <= div - DIV_W'(1);
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (cc_q == '0) begin
               if (nb_q == 4'd1) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  sh_q <= {1'b1, sh_q[FW-1:1]};
                  nb_q <= nb_q - 4'd1;
                  cc_q <= div - DIV_W'(1);
               end
            end else begin
               cc_q <= cc_q - DIV_W'(1);
            end
         end
      end
   end

   assign txd  = busy_q ? sh_q[0] : 1'b1;
   assign busy = busy_q;
   assign done = done_q;

   // R3: a new frame is never loaded over one in flight
   assert_start_idle_R3: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy_q);
endmodule

// File: rtl/uart_txring.sv
module uart_txring
   import uart_txring_pkg::*;
#(
   parameter int DESC_NUM     = 8,
   parameter int DATA_DEPTH   = 64,
   parameter int DIV_W        = 12,
   parameter int HA_W         = 8,
   parameter bit MULTIDROP_EN = 1'b1,
   localparam int IDX_W = $clog2(DESC_NUM),
   localparam int DAW   = $clog2(DATA_DEPTH),
   localparam int GW    = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             host_we,
   input  logic             host_sel,
   input  logic [HA_W-1:0]  host_addr,
   input  logic [15:0]      host_wdata,
   output logic [15:0]      host_rdata,
   input  logic             evt_clear,
   input  logic [IDX_W-1:0] ring_base,
   input  logic [DIV_W-1:0] bit_div,
   input  logic             multidrop,
   input  logic             cts,
   output logic             txd,
   output logic             tx_event
);
   initial begin
      assert (DESC_NUM >= 2 && (DESC_NUM & (DESC_NUM - 1)) == 0)
         else $fatal(1, "DESC_NUM must be a power of two");
      assert (DATA_DEPTH >= 2 && (DATA_DEPTH & (DATA_DEPTH - 1)) == 0)
         else $fatal(1, "DATA_DEPTH must be a power of two");
      assert (HA_W >= IDX_W + 2 && HA_W >= DAW)
         else $fatal(1, "HA_W too narrow for the host address spaces");
   end

   eng_st_t          st_q;
   logic [IDX_W-1:0] idx_q;
   logic [15:0]      rem_q;
   logic [DAW-1:0]   ptr_q;
   logic             started_q, abort_q;
   logic             wrap_q, irq_q, cr_q, adr_q;
   logic [GW-1:0]    gap_q;
   logic             evt_q;

   logic [15:0] desc_rd, eng_status, eng_len, eng_ptr;
   logic [7:0]  dram_rd, eng_byte;
   logic        ser_start, ser_busy, ser_done, eng_wb;
   logic        unused_bits;

   assign unused_bits = ^{host_addr, eng_ptr};
   assign eng_wb      = (st_q == ST_WB);
   assign ser_start   = (st_q == ST_CHAR) && (rem_q != '0) && cts;

   uart_txring_desc #(.DESC_NUM(DESC_NUM)) u_desc (
      .clk        (clk),
      .rst        (rst),
      .host_we    (host_we && !host_sel),
      .host_idx   (host_addr[IDX_W+1:2]),
      .host_word  (host_addr[1:0]),
      .host_wdata (host_wdata),
      .host_rdata (desc_rd),
      .eng_idx    (idx_q),
      .eng_status (eng_status),
      .eng_len    (eng_len),
      .eng_ptr    (eng_ptr),
      .eng_wb     (eng_wb),
      .eng_wb_ct  (abort_q)
   );

   uart_txring_dram #(.DEPTH(DATA_DEPTH)) u_dram (
      .clk        (clk),
      .host_we    (host_we && host_sel),
      .host_addr  (host_addr[DAW-1:0]),
      .host_wdata (host_wdata[7:0]),
      .host_rdata (dram_rd),
      .eng_addr   (ptr_q),
      .eng_rdata  (eng_byte)
   );

   uart_txring_ser #(.DIV_W(DIV_W), .NINTH_EN(MULTIDROP_EN)) u_ser (
      .clk       (clk),
      .rst       (rst),
      .start     (ser_start),
      .data      (eng_byte),
      .ninth_on  (multidrop),
      .ninth_val (adr_q),
      .div       (bit_div),
      .txd       (txd),
      .busy      (ser_busy),
      .done      (ser_done)
   );

   assign host_rdata = host_sel ? {8'h00, dram_rd} : desc_rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q      <= ST_POLL;
         idx_q     <= ring_base;
         rem_q     <= '0;
         ptr_q     <= '0;
         started_q <= 1'b0;
         abort_q   <= 1'b0;
         wrap_q    <= 1'b0;
         irq_q     <= 1'b0;
         cr_q      <= 1'b0;
         adr_q     <= 1'b0;
         gap_q     <= '0;
         evt_q     <= 1'b0;
      end else begin
         evt_q <= (evt_q && !evt_clear) || (eng_wb && irq_q);
         case (st_q)
            ST_POLL: begin
               if (eng_status[RDY_B]) begin
                  rem_q     <= eng_len;
                  ptr_q     <= eng_ptr[DAW-1:0];
                  wrap_q    <= eng_status[WRAP_B];
                  irq_q     <= eng_status[IRQ_B];
                  cr_q      <= eng_status[CR_B];
                  adr_q     <= eng_status[ADR_B];
                  started_q <= 1'b0;
                  abort_q   <= 1'b0;
                  st_q      <= ST_CHAR;
               end
            end
            ST_CHAR: begin
               if (rem_q == '0) begin
                  st_q <= ST_WB;
               end else if (!cts) begin
                  if (cr_q && started_q) begin
                     abort_q <= 1'b1;
                     st_q    <= ST_WB;
                  end
               end else begin
                  started_q <= 1'b1;
                  st_q      <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (ser_done) begin
                  rem_q <= rem_q - 16'd1;
                  ptr_q <= ptr_q + DAW'(1);
                  st_q  <= ST_CHAR;
               end
            end
            ST_WB: begin
               idx_q <= wrap_q ? ring_base : idx_q + IDX_W'(1);
               if (cr_q) begin
                  gap_q <= ({2'b00, bit_div} << 1) + {2'b00, bit_div} - GW'(1);
                  st_q  <= ST_GAP;
               end else begin
                  st_q <= ST_POLL;
               end
            end
            ST_GAP: begin
               if (gap_q == '0) st_q <= ST_POLL;
               else gap_q <= gap_q - GW'(1);
            end
            default: st_q <= ST_POLL;
         endcase
      end
   end

   assign tx_event = evt_q;

   // R9: a character only starts if clear-to-send was high
   assert_cts_gate_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(ser_busy) |-> $past(cts));

   // R6: the event only appears from the write-back of an interrupting descriptor
   assert_evt_source_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_event) |-> $past(st_q == ST_WB && irq_q));
endmodule

// File: tb/uart_txring_bench.sv
module uart_txring_bench;
   localparam int CLK_P = 10;
   localparam int DIV   = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        host_we = 1'b0;
   logic        host_sel = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        evt_clear = 1'b0;
   logic [2:0]  ring_base = 3'd2;
   logic [11:0] bit_div = 12'(DIV);
   logic        multidrop = 1'b0;
   logic        cts = 1'b1;
   logic        txd;
   logic        tx_event;

   int checks = 0;
   int fails  = 0;

   always #(CLK_P/2) clk = ~clk;

   uart_txring u_uart_txring (
      .clk        (clk),
      .rst        (rst),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .evt_clear  (evt_clear),
      .ring_base  (ring_base),
      .bit_div    (bit_div),
      .multidrop  (multidrop),
      .cts        (cts),
      .txd        (txd),
      .tx_event   (tx_event)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      host_sel = sel; host_addr = a; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input logic sel, input logic [7:0] a, output logic [15:0] d);
      @(negedge clk);
      host_sel = sel; host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic set_desc(input int idx, input logic [15:0] len, input logic [15:0] ptr,
                           input logic [15:0] st);
      wr(1'b0, 8'(idx*4 + 1), len);
      wr(1'b0, 8'(idx*4 + 2), ptr);
      wr(1'b0, 8'(idx*4), st);
   endtask

   task automatic wait_start(input string tag);
      int n = 0;
      while (txd !== 1'b0 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 2000) chk({tag, " start bit seen"}, 0, 1);
   endtask

   task automatic read_bits(input logic nine, output logic [7:0] d, output logic b9,
                            output logic st_ok);
      repeat (DIV/2) @(negedge clk);
      st_ok = (txd == 1'b0);
      for (int i = 0; i < 8; i++) begin
         repeat (DIV) @(negedge clk);
         d[i] = txd;
      end
      b9 = 1'b0;
      if (nine) begin
         repeat (DIV) @(negedge clk);
         b9 = txd;
      end
      repeat (DIV) @(negedge clk);
      st_ok = st_ok && (txd == 1'b1);
   endtask

   task automatic rx_byte(input string tag, input logic [7:0] exp, input logic nine,
                          input logic exp9);
      logic [7:0] d; logic b9; logic ok;
      wait_start(tag);
      read_bits(nine, d, b9, ok);
      chk({tag, " data"}, d, exp);
      chk({tag, " start/stop"}, ok, 1);
      if (nine) chk({tag, " ninth"}, b9, exp9);
   endtask

   task automatic idle_count(output int n);
      n = 0;
      while (txd !== 1'b0 && n < 500) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic hold_idle(input string tag, input int cyc);
      logic seen_low = 1'b0;
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) seen_low = 1'b1;
      end
      chk(tag, seen_low, 0);
   endtask

   task automatic pulse_clear;
      @(negedge clk); evt_clear = 1'b1;
      @(negedge clk); evt_clear = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 txd idle", txd, 1);
      chk("R1 event low", tx_event, 0);
      hold_idle("R1 R2 nothing sent while base not ready", 200);
   endtask

   task automatic t_basic;
      logic [15:0] v;
      wr(1'b1, 8'd10, 16'h00A5); wr(1'b1, 8'd11, 16'h003C); wr(1'b1, 8'd12, 16'h000F);
      set_desc(2, 16'd3, 16'd10, 16'hD020);
      rx_byte("R3 byte0", 8'hA5, 1'b0, 1'b0);
      rx_byte("R3 byte1", 8'h3C, 1'b0, 1'b0);
      rx_byte("R3 byte2", 8'h0F, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      rd(1'b0, 8'd8, v);
      chk("R4 status ready cleared, reserved kept", v, 16'h5020);
      chk("R6 event set by interrupt bit", tx_event, 1);
      pulse_clear();
      chk("R6 event cleared by write one", tx_event, 0);
   endtask

   task automatic t_gap;
      int g;
      wr(1'b1, 8'd20, 16'h0011); wr(1'b1, 8'd21, 16'h0022); wr(1'b1, 8'd22, 16'h0033);
      set_desc(5, 16'd1, 16'd22, 16'h8000);
      set_desc(4, 16'd1, 16'd21, 16'h8800);
      set_desc(3, 16'd1, 16'd20, 16'h8000);
      rx_byte("R7 first", 8'h11, 1'b0, 1'b0);
      idle_count(g);
      chk("R7 no-gap under one bit", 32'(g < DIV/2 + DIV), 1);
      rx_byte("R7 second", 8'h22, 1'b0, 1'b0);
      idle_count(g);
      chk("R7 three-bit gap lower", 32'(g >= DIV/2 + 3*DIV), 1);
      chk("R7 three-bit gap upper", 32'(g < DIV/2 + 4*DIV), 1);
      rx_byte("R7 third", 8'h33, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      chk("R6 no event without interrupt bit", tx_event, 0);
   endtask

   task automatic t_wrap;
      logic [15:0] v;
      wr(1'b1, 8'd23, 16'h0044); wr(1'b1, 8'd24, 16'h0077); wr(1'b1, 8'd25, 16'h0088);
      set_desc(7, 16'd1, 16'd25, 16'h8000);
      set_desc(2, 16'd1, 16'd24, 16'h8000);
      set_desc(6, 16'd1, 16'd23, 16'hA000);
      rx_byte("R5 last desc", 8'h44, 1'b0, 1'b0);
      rx_byte("R5 wrapped to base", 8'h77, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      rd(1'b0, 8'd28, v);
      chk("R5 desc after wrap not visited", v, 16'h8000);
      wr(1'b0, 8'd29, 16'd5);
      rd(1'b0, 8'd29, v);
      chk("R11 owned length write ignored", v, 16'd1);
      wr(1'b0, 8'd28, 16'h0000);
      rd(1'b0, 8'd28, v);
      chk("R11 owned status write ignored", v, 16'h8000);
   endtask

   task automatic t_multidrop;
      wr(1'b1, 8'd30, 16'h0081); wr(1'b1, 8'd31, 16'h0042); wr(1'b1, 8'd32, 16'h00E7);
      multidrop = 1'b1;
      set_desc(4, 16'd1, 16'd32, 16'h8000);
      set_desc(3, 16'd2, 16'd30, 16'h8400);
      rx_byte("R8 address char 0", 8'h81, 1'b1, 1'b1);
      rx_byte("R8 address char 1", 8'h42, 1'b1, 1'b1);
      rx_byte("R8 data char", 8'hE7, 1'b1, 1'b0);
      repeat (10) @(negedge clk);
      multidrop = 1'b0;
   endtask

   task automatic t_abort;
      logic [15:0] v; logic [7:0] d; logic b9; logic ok;
      wr(1'b1, 8'd40, 16'h005A); wr(1'b1, 8'd41, 16'h0066); wr(1'b1, 8'd42, 16'h0099);
      set_desc(5, 16'd3, 16'd40, 16'h9800);
      wait_start("R10");
      cts = 1'b0;
      read_bits(1'b0, d, b9, ok);
      chk("R10 char in flight finishes", d, 8'h5A);
      hold_idle("R10 no further chars", 40*DIV);
      rd(1'b0, 8'd20, v);
      chk("R10 status CT set, ready cleared", v, 16'h1801);
      chk("R10 event raised", tx_event, 1);
      pulse_clear();
      cts = 1'b1;
      hold_idle("R10 aborted buffer not resumed", 20*DIV);
   endtask

   task automatic t_pause;
      logic [15:0] v; logic [7:0] d; logic b9; logic ok;
      wr(1'b1, 8'd44, 16'h00C3); wr(1'b1, 8'd45, 16'h0018);
      set_desc(6, 16'd2, 16'd44, 16'hA000);
      wait_start("R9");
      cts = 1'b0;
      read_bits(1'b0, d, b9, ok);
      chk("R9 first char", d, 8'hC3);
      hold_idle("R9 paused while cts low", 10*DIV);
      cts = 1'b1;
      rx_byte("R9 resumed char", 8'h18, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      rd(1'b0, 8'd24, v);
      chk("R9 status CT clear", v, 16'h2000);
      chk("R9 no event", tx_event, 0);
   endtask

   task automatic t_zero;
      logic [15:0] v;
      set_desc(2, 16'd0, 16'd0, 16'h9000);
      hold_idle("R12 zero length sends nothing", 100);
      rd(1'b0, 8'd8, v);
      chk("R12 zero length returned", v, 16'h1000);
      chk("R12 event raised", tx_event, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_basic();
      t_gap();
      t_wrap();
      t_multidrop();
      t_abort();
      t_pause();
      t_zero();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule